// File: doc/BRIEF.md
# Buffered PWM Channel Pair

This block pairs two output-compare channels that share one free-running counter and drives a single PWM pin from them. The counter is outside the block. The block sees the counter value and a one-cycle strobe. The strobe marks the cycle in which the counter has wrapped to zero, which begins a new period. Software-style register writes arrive over a plain strobe port, which is always accepted and has no back-pressure. Each write loads either a channel's compare value or its control word.

In linked mode, the two compare registers take turns. Each period boundary hands control of the pin to the other register. Software can therefore prepare the next duty value in the idle register without disturbing the period in progress. In single mode, channel 0 drives the pin alone and reuses its own compare value every period. Exact 0% duty comes from disabling the set-at-wrap action. Exact 100% duty comes from a force bit combined with that action, so no compare value is needed for either extreme.

Each channel has a match flag with an optional interrupt request. A flag is cleared by a two-step handshake: an acknowledge strobe while the flag is set, then a control write with the flag bit at 0.

Top module: `pwm_pair`

## Requirements
- R1: After reset, `pwm_out`, both `chan_flag` bits and both `chan_irq` bits are 0.
- R2: Control word bit 3 (link) of channel 0 joins the two channels into one buffered generator. When bit 3 is set, it overrides bit 2 (single) of channel 0, and channel 1's bit 2 has no effect.
- R3: While link is off, channel 0's register is the active one. Once linked, channel 0 stays active until the first wrap strobe. Every later wrap strobe swaps the active register, and the swap applies in the wrap cycle itself.
- R4: With bit 4 (set-at-wrap) on, the wrap cycle drives the pin to its active level. A cycle whose counter value equals the active compare value drives the pin to its inactive level, and a match wins over a wrap in the same cycle. The pin changes one clock after the deciding cycle, so a compare value C below the period gives C active cycles per period.
- R5: Bit 6 picks the active level: 1 means high, 0 means low.
- R6: With set-at-wrap off and the force bit off, the pin holds its inactive level after the next match (0% duty).
- R7: With bit 5 (force) and set-at-wrap both on, the pin is held at its active level (100% duty).
- R8: A compare write to the idle register leaves the current period unchanged. The new value governs the next period in which that register is active.
- R9: A channel's flag (`chan_flag`) is set one clock after a match of that channel. In linked mode, only the active register's channel can match. `chan_irq` is high when the flag is set and bit 1 of that channel's control word is set.
- R10: A flag is cleared by a control write with bit 0 at 0 only if an acknowledge of that channel saw the flag set after the channel's last control write. If a match of the same channel occurs in the clearing cycle, the flag stays set.
- R11: In single mode (bit 2 set, link off), channel 0 drives the pin from its own compare value every period. Channel 1 with bit 2 set only raises its flag on its own matches. With neither link nor single on channel 0, the pin is 0 whatever bit 6 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | CW | Shared counter value |
| cnt_ovf | input | 1 | High in the cycle the counter has wrapped to zero |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel addressed by the write |
| wr_ctl | input | 1 | 1: write control word, 0: write compare value |
| wr_data | input | CW | Write data; control bits 0..6 as in the requirements |
| rd_ack | input | 1 | Flag acknowledge strobe (first clear step) |
| rd_ch | input | 1 | Channel acknowledged |
| pwm_out | output | 1 | PWM pin level |
| chan_flag | output | 2 | Per-channel match flags |
| chan_irq | output | 2 | Per-channel interrupt requests |

## Verification
Every result of this block is registered. A counter value, wrap strobe or register write sampled at a rising edge shows up on the pin, flags and interrupt lines right after that same edge. A write therefore influences matching from the next counter value on. The bench drives all inputs and samples all outputs at falling edges. Its behavioural model advances on rising edges, so each comparison lands exactly one edge after the stimulus. Duty is summed per period from the samples taken with counter values 0 through period-1. This makes the one-clock pin latency line up with a C-cycle expectation.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  // control word bit positions (shared by writer and decoder)
  localparam int unsigned B_FLAG   = 0;
  localparam int unsigned B_IE     = 1;
  localparam int unsigned B_SINGLE = 2;
  localparam int unsigned B_LINK   = 3;
  localparam int unsigned B_WRAP   = 4;
  localparam int unsigned B_FULL   = 5;
  localparam int unsigned B_POL    = 6;
  localparam int unsigned CTL_BITS = 7;

  typedef struct packed {
    logic act_high;
    logic force_full;
    logic wrap_set;
    logic link_en;
    logic single_en;
    logic irq_en;
  } ctl_t;

  function automatic ctl_t decode_ctl(input logic [CTL_BITS-1:0] w);
    ctl_t c;
    c.act_high   = w[B_POL];
    c.force_full = w[B_FULL];
    c.wrap_set   = w[B_WRAP];
    c.link_en    = w[B_LINK];
    c.single_en  = w[B_SINGLE];
    c.irq_en     = w[B_IE];
    return c;
  endfunction
endpackage

// File: rtl/cmp_chan.sv
module cmp_chan
  import pwm_pair_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmp,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_ack,
  input  logic          hit_ev,
  output logic [CW-1:0] cmp_q,
  output ctl_t          ctl_q,
  output logic          flag_q,
  output logic          irq
);
  logic arm_q;
  logic clr_req;

  assign clr_req = wr_ctl && arm_q && !wr_data[B_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_cmp) cmp_q <= wr_data;
      if (wr_ctl) ctl_q <= decode_ctl(wr_data[CTL_BITS-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctl)      arm_q <= 1'b0;
      else if (rd_ack) arm_q <= flag_q;
      if (hit_ev)       flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  assign irq = flag_q & ctl_q.irq_en;

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> flag_q);
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !arm_q) |=> flag_q);
endmodule

// File: rtl/pwm_edge.sv
module pwm_edge #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_ovf,
  input  logic [CW-1:0] cmp0,
  input  logic [CW-1:0] cmp1,
  input  logic          link,
  input  logic          single0,
  input  logic          single1,
  input  logic          wrap_set,
  input  logic          force_full,
  input  logic          act_high,
  output logic [1:0]    hit,
  output logic          pwm_out
);
  logic sel_q, act_q, out_q;
  logic drive, eff_sel, eq0, eq1, any_hit, act_d;

  assign drive   = link | single0;
  assign eff_sel = link & (sel_q ^ cnt_ovf);
  assign eq0     = (cnt_val == cmp0);
  assign eq1     = (cnt_val == cmp1);

  always_comb begin
    if (link) begin
      hit[0] = eq0 & ~eff_sel;
      hit[1] = eq1 &  eff_sel;
    end else begin
      hit[0] = eq0 & single0;
      hit[1] = eq1 & single1;
    end
  end

  assign any_hit = link ? (hit[0] | hit[1]) : hit[0];

  always_comb begin
    if (!drive)                      act_d = 1'b0;
    else if (force_full && wrap_set) act_d = 1'b1;
    else if (any_hit)                act_d = 1'b0;
    else if (cnt_ovf && wrap_set)    act_d = 1'b1;
    else                             act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      act_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      sel_q <= eff_sel;
      act_q <= act_d;
      out_q <= drive & (act_high ? act_d : ~act_d);
    end
  end

  assign pwm_out = out_q;

  // R3
  sel_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link && cnt_ovf) |=> (sel_q != $past(sel_q)));
  // R7
  full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && force_full && wrap_set) |=> (pwm_out == $past(act_high)));
  // R6
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && !wrap_set && $stable(act_high) && (pwm_out != act_high))
      |=> (pwm_out == !$past(act_high)));
  // R9
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link |-> $onehot0(hit));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_ovf,
  input  logic          wr_en,
  input  logic          wr_ch,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_ack,
  input  logic          rd_ch,
  output logic          pwm_out,
  output logic [1:0]    chan_flag,
  output logic [1:0]    chan_irq
);
  localparam int unsigned NCH = 2;

  logic [CW-1:0] cmp_a [NCH];
  ctl_t          ctl_a [NCH];
  logic [NCH-1:0] hit;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cmp_chan #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_cmp  (wr_en && !wr_ctl && (wr_ch == 1'(i))),
      .wr_ctl  (wr_en &&  wr_ctl && (wr_ch == 1'(i))),
      .wr_data (wr_data),
      .rd_ack  (rd_ack && (rd_ch == 1'(i))),
      .hit_ev  (hit[i]),
      .cmp_q   (cmp_a[i]),
      .ctl_q   (ctl_a[i]),
      .flag_q  (chan_flag[i]),
      .irq     (chan_irq[i])
    );
  end

  pwm_edge #(.CW(CW)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_val    (cnt_val),
    .cnt_ovf    (cnt_ovf),
    .cmp0       (cmp_a[0]),
    .cmp1       (cmp_a[1]),
    .link       (ctl_a[0].link_en),
    .single0    (ctl_a[0].single_en),
    .single1    (ctl_a[1].single_en),
    .wrap_set   (ctl_a[0].wrap_set),
    .force_full (ctl_a[0].force_full),
    .act_high   (ctl_a[0].act_high),
    .hit        (hit),
    .pwm_out    (pwm_out)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!pwm_out && chan_flag == 2'b00) || !rst_n);
endmodule

// File: tb/pwm_pair_bench.sv
module pwm_pair_bench;
  localparam int CW = 16;
  localparam int P  = 20;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cnt_val = 0;
  logic cnt_ovf = 0;
  logic wr_en = 0, wr_ch = 0, wr_ctl = 0;
  logic [CW-1:0] wr_data = 0;
  logic rd_ack = 0, rd_ch = 0;
  logic pwm_out;
  logic [1:0] chan_flag, chan_irq;

  int checks = 0, failures = 0, cyc = 0, acc = 0;
  int duty_q[$];
  bit model_on = 0;

  int m_cmp[2], m_ctl[2];
  bit m_flag[2], m_arm[2];
  bit m_sel, m_act, m_out;

  pwm_pair #(.CW(CW)) u_pwm_pair (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .rd_ack(rd_ack), .rd_ch(rd_ch), .pwm_out(pwm_out),
    .chan_flag(chan_flag), .chan_irq(chan_irq));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit lk, s0, s1, wr, fu, pl, drv, es, mt, nact, old_f0, old_f1;
    bit h[2];
    if (!rst_n) begin
      m_cmp[0] = 0; m_cmp[1] = 0; m_ctl[0] = 0; m_ctl[1] = 0;
      m_flag[0] = 0; m_flag[1] = 0; m_arm[0] = 0; m_arm[1] = 0;
      m_sel = 0; m_act = 0; m_out = 0;
    end else begin
      lk = m_ctl[0][3]; s0 = m_ctl[0][2]; s1 = m_ctl[1][2];
      wr = m_ctl[0][4]; fu = m_ctl[0][5]; pl = m_ctl[0][6];
      drv = lk || s0;
      es = lk && (m_sel != cnt_ovf);
      if (lk) begin
        h[0] = (int'(cnt_val) == m_cmp[0]) && !es;
        h[1] = (int'(cnt_val) == m_cmp[1]) && es;
        mt = h[0] || h[1];
      end else begin
        h[0] = (int'(cnt_val) == m_cmp[0]) && s0;
        h[1] = (int'(cnt_val) == m_cmp[1]) && s1;
        mt = h[0];
      end
      if (!drv) nact = 0;
      else if (fu && wr) nact = 1;
      else if (mt) nact = 0;
      else if (cnt_ovf && wr) nact = 1;
      else nact = m_act;
      m_out = drv && (pl ? nact : !nact);
      m_act = nact;
      m_sel = es;
      old_f0 = m_flag[0]; old_f1 = m_flag[1];
      for (int c = 0; c < 2; c++) begin
        bit cw;
        cw = wr_en && wr_ctl && (int'(wr_ch) == c);
        if (h[c]) m_flag[c] = 1;
        else if (cw && m_arm[c] && !wr_data[0]) m_flag[c] = 0;
        if (cw) m_arm[c] = 0;
        else if (rd_ack && int'(rd_ch) == c) m_arm[c] = (c == 0) ? old_f0 : old_f1;
      end
      if (wr_en && !wr_ctl) m_cmp[wr_ch] = int'(wr_data);
      if (wr_en && wr_ctl) m_ctl[wr_ch] = int'(wr_data[6:0]);
    end
  end

  // compare, duty monitor, counter drive, watchdog: all at falling edges
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (model_on) begin
      chk("R4 pwm_out vs model", pwm_out, m_out);
      chk("R9 flag0 vs model", chan_flag[0], m_flag[0]);
      chk("R9 flag1 vs model", chan_flag[1], m_flag[1]);
      chk("R9 irq0 vs model", chan_irq[0], m_flag[0] && m_ctl[0][1]);
      chk("R9 irq1 vs model", chan_irq[1], m_flag[1] && m_ctl[1][1]);
    end
    if (rst_n) begin
      acc += pwm_out;
      if (int'(cnt_val) == P-1) begin duty_q.push_back(acc); acc = 0; end
      cnt_val = (int'(cnt_val) == P-1) ? '0 : cnt_val + 1'b1;
      cnt_ovf = (cnt_val == 0);
    end
  end

  task automatic wr(input bit ch, input bit ctl, input int d);
    @(negedge clk); wr_en = 1; wr_ch = ch; wr_ctl = ctl; wr_data = CW'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ack(input bit ch);
    @(negedge clk); rd_ack = 1; rd_ch = ch;
    @(negedge clk); rd_ack = 0;
  endtask

  task automatic wait_boundary();
    do @(posedge clk); while (!cnt_ovf);
    duty_q.delete();
  endtask

  task automatic wait_q(input int n);
    while (duty_q.size() < n) @(posedge clk);
  endtask

  initial begin
    int a, b;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 pwm_out in reset", pwm_out, 0);
    chk("R1 flags in reset", chan_flag, 0);
    chk("R1 irqs in reset", chan_irq, 0);
    rst_n = 1; model_on = 1;

    // R3: linked, ch1 governs the first full period, then ch0
    wr(0, 0, 5); wr(1, 0, 12); wr(0, 1, 'h58);
    wait_boundary();
    wait_q(2);
    chk("R3 first period from ch1", duty_q.pop_front(), 12);
    chk("R3 second period from ch0", duty_q.pop_front(), 5);

    // R8: idle-register updates between periods (ch1 active now)
    wr(0, 0, 8);
    wait_q(1);
    wr(1, 0, 15);
    wait_q(3);
    chk("R8 current period kept", duty_q.pop_front(), 12);
    chk("R8 ch0 update seamless", duty_q.pop_front(), 8);
    chk("R8 ch1 update seamless", duty_q.pop_front(), 15);

    // R5: active-low level
    wr(0, 1, 'h18);
    wait_boundary(); wait_q(2);
    a = duty_q.pop_front(); b = duty_q.pop_front();
    chk("R5 active-low high cycles", a + b, 2*P - 23);

    // R6: 0% duty without set-at-wrap
    wr(0, 1, 'h48);
    wait_boundary(); wait_q(2);
    chk("R6 zero duty p1", duty_q.pop_front(), 0);
    chk("R6 zero duty p2", duty_q.pop_front(), 0);

    // R7: 100% duty
    wr(0, 1, 'h78);
    wait_boundary(); wait_q(2);
    chk("R7 full duty p1", duty_q.pop_front(), P);
    chk("R7 full duty p2", duty_q.pop_front(), P);

    // R2: link overrides single
    wr(0, 0, 4); wr(1, 0, 9); wr(0, 1, 'h5C);
    wait_boundary(); wait_q(2);
    a = duty_q.pop_front(); b = duty_q.pop_front();
    chk("R2 linked sum", a + b, 13);
    chk("R2 linked alternates", a != b, 1);

    // R11: single mode, ch1 flag only
    wr(0, 1, 'h54); wr(1, 1, 'h04);
    wait_boundary(); wait_q(2);
    chk("R11 single p1", duty_q.pop_front(), 4);
    chk("R11 single p2", duty_q.pop_front(), 4);
    ack(1); wr(1, 1, 'h04);
    chk("R10 ch1 cleared after ack", chan_flag[1], 0);
    wait_q(1); duty_q.delete();
    chk("R11 ch1 flag on own match", chan_flag[1], 1);

    // R11: no drive -> pin low for either level choice
    wr(0, 1, 'h50);
    wait_boundary(); wait_q(1);
    chk("R11 idle pin pol high", duty_q.pop_front(), 0);
    wr(0, 1, 'h10);
    wait_boundary(); wait_q(1);
    chk("R11 idle pin pol low", duty_q.pop_front(), 0);

    // R9 / R10 flag handling in single mode, compare 15
    wr(0, 0, 15); wr(0, 1, 'h56);
    wait_boundary(); wait_q(1); duty_q.delete();
    chk("R9 irq0 with enable", chan_irq[0], 1);
    wr(0, 1, 'h54);
    chk("R10 no-ack write keeps flag", chan_flag[0], 1);
    chk("R9 irq0 without enable", chan_irq[0], 0);
    ack(0); wr(0, 1, 'h54);
    chk("R10 ack then write clears", chan_flag[0], 0);
    wait_q(1); duty_q.delete();
    ack(0);
    do @(posedge clk); while (int'(cnt_val) != 14);
    wr(0, 1, 'h54);
    chk("R10 match beats clear", chan_flag[0], 1);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule